// File: doc/BRIEF.md
# Data Access Protection Checker

This block sits beside a data memory pipeline. It screens every load and store against a table of protection descriptors. Each descriptor holds a page base address and a word of attributes: a valid flag, a page size, permission flags for user and supervisor, a dirty flag and a flag that confines the page to address generator 0. Each access arrives with four facts: its address, whether it reads or writes, whether the core runs in user or supervisor mode, and which of the two address generators issued it. For each access the block returns one verdict, pass or protection fault. A faulting verdict carries the exception cause 0x23.

Software reaches the descriptors, a control word with the global check enable, and two fault registers through a simple word-addressed register bus. Reads on this bus are combinational. On every fault the block captures the full access address and a syndrome word. The syndrome records the privilege mode, the direction, the generator and a one-hot flag for the descriptor that matched. Software clears both registers by writing zero to them. Accesses enter on a valid/ready request channel, and verdicts leave on a valid/ready response channel. The block holds one verdict and stalls new requests while that verdict is refused.

Top module: `dmem_guard`

## Requirements
- R1: After reset the response channel is empty, the control word reads 0 (checking off), and the fault address and syndrome registers read 0.
- R2: While control bit 0 is clear, every access returns pass with cause 0.
- R3: A descriptor matches when attribute bit 0 (valid) is set and the access address equals the base with the low page bits ignored. Attribute bits [17:16] give the page size: 0 = 1 KB, 1 = 4 KB, 2 = 1 MB, 3 = 4 MB. An access that matches no descriptor passes.
- R4: When several descriptors match, the lowest-numbered one alone decides the verdict and is named in the syndrome.
- R5: A supervisor write faults when attribute bit 3 (supervisor write) is clear. A supervisor read never faults on permission.
- R6: A user write faults unless attribute bit 2 (user read-write) is set. A user read faults unless bit 1 (user read-only) or bit 2 is set.
- R7: A write to a page whose attribute bit 4 (dirty) is clear faults even when its permissions allow it.
- R8: An access from generator 1 to a page with attribute bit 5 (generator 0 only) set faults.
- R9: A faulting verdict carries cause 0x23. A passing verdict carries fault 0 and cause 0.
- R10: On a fault the fault address register takes the full access address. The syndrome takes the one-hot matched descriptor in bits [15:0], write in bit 16, user in bit 17 and generator 1 in bit 18. A passing access leaves both registers unchanged.
- R11: A bus write to the fault address (word 33) or syndrome (word 34) register loads the written value, so writing zero clears it. A fault captured in the same cycle takes precedence.
- R12: A verdict appears on the response channel in the cycle after the request is accepted. A request is accepted only while the response slot is empty or being taken. A refused verdict holds steady.
- R13: Register words: 0..15 descriptor bases, 16..31 descriptor attributes (only bits 0..5 and 16..17 are kept, the rest read 0), 32 control, 33 fault address, 34 syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Access request accepted this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_user | input | 1 | 1 = user mode, 0 = supervisor |
| acc_gen1 | input | 1 | 1 = issued by address generator 1 |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_fault | output | 1 | Verdict is a protection fault |
| rsp_cause | output | 6 | Exception cause, 0x23 on fault, else 0 |
| reg_we | input | 1 | Register bus write strobe |
| reg_addr | input | 6 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The verdict for a request accepted at one rising edge is due on the response outputs right after that edge. The fault address and syndrome show the capture from that same edge on the combinational read port. A descriptor or control write takes effect for requests accepted at any later edge. The bench drives all inputs and samples all outputs on falling edges. Its reference model advances at each rising edge and is compared with the response channel and the request ready on every falling edge. Explicit register reads are taken a step after a falling edge, once the read address has settled.

// File: rtl/dmg_pkg.sv
package dmg_pkg;
  localparam int BIT_VALID = 0;
  localparam int BIT_URD   = 1;
  localparam int BIT_URW   = 2;
  localparam int BIT_SWR   = 3;
  localparam int BIT_DIRTY = 4;
  localparam int BIT_G0    = 5;
  localparam int BIT_SZ    = 16;

  localparam logic [5:0] CAUSE_PROT = 6'h23;

  typedef struct packed {
    logic g0_only;
    logic dirty;
    logic sup_wr;
    logic user_rw;
    logic user_rd;
  } perm_t;

  typedef struct packed {
    logic [1:0] size;
    perm_t      perm;
    logic       valid;
  } attr_t;

  function automatic int page_shift(input logic [1:0] sz);
    case (sz)
      2'd0:    return 10;
      2'd1:    return 12;
      2'd2:    return 20;
      default: return 22;
    endcase
  endfunction

  function automatic logic [31:0] attr_word(input attr_t a);
    logic [31:0] w;
    w = '0;
    w[BIT_VALID] = a.valid;
    w[BIT_URD]   = a.perm.user_rd;
    w[BIT_URW]   = a.perm.user_rw;
    w[BIT_SWR]   = a.perm.sup_wr;
    w[BIT_DIRTY] = a.perm.dirty;
    w[BIT_G0]    = a.perm.g0_only;
    w[BIT_SZ+1:BIT_SZ] = a.size;
    return w;
  endfunction
endpackage

// File: rtl/dmg_regfile.sv
module dmg_regfile
  import dmg_pkg::*;
#(
  parameter int N   = 16,
  parameter int AW  = 32,
  parameter int RAW = 6,
  parameter int SW  = N + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [RAW-1:0]       reg_addr,
  input  logic [AW-1:0]        reg_wdata,
  output logic [AW-1:0]        reg_rdata,
  output logic [N-1:0][AW-1:0] base_o,
  output attr_t [N-1:0]        attr_o,
  output logic                 chk_en,
  input  logic                 cap_en,
  input  logic [AW-1:0]        cap_addr,
  input  logic [SW-1:0]        cap_stat
);
  localparam int ATTR_OFS  = N;
  localparam int CTRL_IDX  = 2 * N;
  localparam int FADDR_IDX = 2 * N + 1;
  localparam int FSTAT_IDX = 2 * N + 2;

  logic [AW-1:0] fault_addr;
  logic [SW-1:0] fault_stat;
  attr_t         wr_attr;

  always_comb begin
    wr_attr.valid        = reg_wdata[BIT_VALID];
    wr_attr.perm.user_rd = reg_wdata[BIT_URD];
    wr_attr.perm.user_rw = reg_wdata[BIT_URW];
    wr_attr.perm.sup_wr  = reg_wdata[BIT_SWR];
    wr_attr.perm.dirty   = reg_wdata[BIT_DIRTY];
    wr_attr.perm.g0_only = reg_wdata[BIT_G0];
    wr_attr.size         = reg_wdata[BIT_SZ+1:BIT_SZ];
  end

  for (genvar i = 0; i < N; i++) begin : g_desc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[i] <= '0;
        attr_o[i] <= '0;
      end else if (reg_we) begin
        if (reg_addr == RAW'(i))            base_o[i] <= reg_wdata;
        if (reg_addr == RAW'(ATTR_OFS + i)) attr_o[i] <= wr_attr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_en <= 1'b0;
    else if (reg_we && reg_addr == RAW'(CTRL_IDX)) chk_en <= reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr <= '0;
      fault_stat <= '0;
    end else if (cap_en) begin
      fault_addr <= cap_addr;
      fault_stat <= cap_stat;
    end else if (reg_we) begin
      if (reg_addr == RAW'(FADDR_IDX)) fault_addr <= reg_wdata;
      if (reg_addr == RAW'(FSTAT_IDX)) fault_stat <= reg_wdata[SW-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (reg_addr == RAW'(i))            reg_rdata = base_o[i];
      if (reg_addr == RAW'(ATTR_OFS + i)) reg_rdata = AW'(attr_word(attr_o[i]));
    end
    if (reg_addr == RAW'(CTRL_IDX))  reg_rdata = AW'(chk_en);
    if (reg_addr == RAW'(FADDR_IDX)) reg_rdata = fault_addr;
    if (reg_addr == RAW'(FSTAT_IDX)) reg_rdata = AW'(fault_stat);
  end

  // R10: capture loads the access address
  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> fault_addr == $past(cap_addr));

  // R11: software write without a competing capture loads the value
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RAW'(FSTAT_IDX) && !cap_en)
      |=> fault_stat == $past(reg_wdata[SW-1:0]));
endmodule

// File: rtl/dmg_match.sv
module dmg_match
  import dmg_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 32
) (
  input  logic [AW-1:0]        addr,
  input  logic [N-1:0][AW-1:0] base,
  input  attr_t [N-1:0]        attr,
  output logic                 hit_any,
  output logic [N-1:0]         hit_oh,
  output perm_t                sel_perm
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [AW-1:0] keep;
    always_comb begin
      keep   = ~((AW'(1) << page_shift(attr[i].size)) - AW'(1));
      hit[i] = attr[i].valid && (((addr ^ base[i]) & keep) == '0);
    end
  end

  always_comb begin
    hit_oh  = '0;
    hit_any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit[i] && !hit_any) begin
        hit_oh[i] = 1'b1;
        hit_any   = 1'b1;
      end
    end
  end

  always_comb begin
    sel_perm = '0;
    for (int i = 0; i < N; i++)
      if (hit_oh[i]) sel_perm = sel_perm | attr[i].perm;
  end
endmodule

// File: rtl/dmg_perm.sv
module dmg_perm
  import dmg_pkg::*;
(
  input  perm_t p,
  input  logic  is_write,
  input  logic  is_user,
  input  logic  is_gen1,
  output logic  viol
);
  logic bad_user_wr, bad_user_rd, bad_sup_wr, bad_clean, bad_gen;

  always_comb begin
    bad_user_wr = is_write && is_user && !p.user_rw;
    bad_user_rd = !is_write && is_user && !(p.user_rd || p.user_rw);
    bad_sup_wr  = is_write && !is_user && !p.sup_wr;
    bad_clean   = is_write && !p.dirty;
    bad_gen     = is_gen1 && p.g0_only;
    viol = bad_user_wr | bad_user_rd | bad_sup_wr | bad_clean | bad_gen;
  end
endmodule

// File: rtl/dmem_guard.sv
module dmem_guard
  import dmg_pkg::*;
#(
  parameter int N_DESC = 16,
  parameter int ADDR_W = 32,
  localparam int REG_AW = $clog2(2 * N_DESC + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_user,
  input  logic              acc_gen1,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [5:0]        rsp_cause,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata
);
  localparam int STAT_W = N_DESC + 3;

  logic [N_DESC-1:0][ADDR_W-1:0] base;
  attr_t [N_DESC-1:0]            attr;
  logic                          chk_en;
  logic                          hit_any;
  logic [N_DESC-1:0]             hit_oh;
  perm_t                         sel_perm;
  logic                          viol;
  logic                          fire;
  logic                          fault_now;
  logic [STAT_W-1:0]             syndrome;

  assign acc_ready = !rsp_valid || rsp_ready;
  assign fire      = acc_valid && acc_ready;
  assign fault_now = chk_en && hit_any && viol;
  assign syndrome  = {acc_gen1, acc_user, acc_write, hit_oh};

  dmg_regfile #(.N(N_DESC), .AW(ADDR_W), .RAW(REG_AW), .SW(STAT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .base_o   (base),
    .attr_o   (attr),
    .chk_en   (chk_en),
    .cap_en   (fire && fault_now),
    .cap_addr (acc_addr),
    .cap_stat (syndrome)
  );

  dmg_match #(.N(N_DESC), .AW(ADDR_W)) u_match (
    .addr    (acc_addr),
    .base    (base),
    .attr    (attr),
    .hit_any (hit_any),
    .hit_oh  (hit_oh),
    .sel_perm(sel_perm)
  );

  dmg_perm u_perm (
    .p       (sel_perm),
    .is_write(acc_write),
    .is_user (acc_user),
    .is_gen1 (acc_gen1),
    .viol    (viol)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_fault <= fault_now;
      rsp_cause <= fault_now ? CAUSE_PROT : 6'd0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R12: accepted request yields a verdict next cycle
  p_resp_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  // R12: refused verdict holds
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready)
      |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_cause)));

  // R9: cause follows the verdict
  p_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault ? rsp_cause == CAUSE_PROT : rsp_cause == 6'd0));

  // R2: checking off never faults
  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !chk_en) |=> !rsp_fault);

  // R4: at most one descriptor is selected
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> $onehot(hit_oh));
endmodule

// File: tb/dmem_guard_test.sv
`timescale 1ns/1ps
module dmem_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_user = 1'b0;
  logic        acc_gen1 = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [5:0]  rsp_cause;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad = 0;
  bit live = 0;

  always #2.5 clk = ~clk;

  dmem_guard uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_user(acc_user), .acc_gen1(acc_gen1),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // behavioural reference model
  logic [31:0] mb [16];
  logic [31:0] ma [16];
  bit          m_en;
  logic [31:0] m_fa, m_st;
  bit          m_rv, m_rf;

  task automatic ref_eval(input logic [31:0] a, input bit w, u, g,
                          output bit f, output logic [31:0] st);
    int idx = -1;
    for (int i = 0; i < 16; i++) begin
      int sh;
      case (ma[i][17:16])
        2'd0: sh = 10;
        2'd1: sh = 12;
        2'd2: sh = 20;
        default: sh = 22;
      endcase
      if (idx < 0 && ma[i][0] && ((a >> sh) == (mb[i] >> sh))) idx = i;
    end
    f = 0;
    st = {13'd0, g, u, w, 16'd0};
    if (idx >= 0) begin
      logic [31:0] at = ma[idx];
      st[idx] = 1'b1;
      if (m_en) begin
        if (w && u && !at[2]) f = 1;
        if (!w && u && !at[1] && !at[2]) f = 1;
        if (w && !u && !at[3]) f = 1;
        if (w && !at[4]) f = 1;
        if (g && at[5]) f = 1;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin mb[i] = 0; ma[i] = 0; end
      m_en = 0; m_fa = 0; m_st = 0; m_rv = 0; m_rf = 0;
    end else begin
      bit f; logic [31:0] st; bit cap;
      cap = 0;
      if (acc_valid && (!m_rv || rsp_ready)) begin
        ref_eval(acc_addr, acc_write, acc_user, acc_gen1, f, st);
        m_rv = 1; m_rf = f;
        if (f) begin m_fa = acc_addr; m_st = st; cap = 1; end
      end else if (rsp_ready) begin
        m_rv = 0;
      end
      if (reg_we) begin
        if (reg_addr < 16) mb[reg_addr] = reg_wdata;
        else if (reg_addr < 32) ma[reg_addr-16] = reg_wdata & 32'h0003_003F;
        else if (reg_addr == 32) m_en = reg_wdata[0];
        else if (reg_addr == 33 && !cap) m_fa = reg_wdata;
        else if (reg_addr == 34 && !cap) m_st = reg_wdata & 32'h0007_FFFF;
      end
    end
  end

  // per-cycle comparison on the falling edge (R12, R9)
  always @(negedge clk) begin
    if (live) begin
      total++;
      if (acc_ready !== (!m_rv || rsp_ready) || rsp_valid !== m_rv ||
          (m_rv && (rsp_fault !== m_rf || rsp_cause !== (m_rf ? 6'h23 : 6'h00)))) begin
        bad++;
        $display("FAIL R12 R9 cycle: rdy=%0b v=%0b f=%0b c=%0h expected rdy=%0b v=%0b f=%0b",
                 acc_ready, rsp_valid, rsp_fault, rsp_cause, !m_rv || rsp_ready, m_rv, m_rf);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_check(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = 6'(a);
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic access(input logic [31:0] a, input bit w, u, g, input bit exp_f,
                        input string tag);
    @(negedge clk);
    acc_addr = a; acc_write = w; acc_user = u; acc_gen1 = g; acc_valid = 1'b1;
    #1;
    while (!acc_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
    check({tag, " verdict"}, {31'd0, rsp_fault}, {31'd0, exp_f});
    check({tag, " cause"}, {26'd0, rsp_cause}, exp_f ? 32'h23 : 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;
    // R1 reset state
    check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    reg_check(32, 0, "R1 control");
    reg_check(33, 0, "R1 fault addr");
    reg_check(34, 0, "R1 syndrome");

    reg_write(0, 32'h800);       reg_write(16, 32'h11);
    reg_write(1, 32'h1000);      reg_write(17, 32'h11);
    reg_write(2, 32'h2000);      reg_write(18, 32'h11);
    reg_write(3, 32'h3000);      reg_write(19, 32'h0D);
    reg_write(4, 32'h4000);      reg_write(20, 32'h3D);
    reg_write(5, 32'h00C0_0000); reg_write(21, 32'h0003_0019);
    reg_write(6, 32'h3000);      reg_write(22, 32'h1D);
    reg_write(7, 32'h0001_0000); reg_write(23, 32'h0001_0019);
    reg_write(8, 32'h8000);      reg_write(24, 32'h1C);
    reg_write(9, 32'hF000_0000); reg_write(25, 32'hFFFF_FFFF);

    // R13 register map and kept attribute bits
    reg_check(21, 32'h0003_0019, "R13 attr d5");
    reg_check(25, 32'h0003_003F, "R13 attr d9 masked");
    reg_check(7, 32'h0001_0000, "R13 base d7");

    // R2 disabled
    access(32'h800, 1, 0, 0, 0, "R2 disabled sup write");
    reg_check(33, 0, "R2 no capture");

    reg_write(32, 1);
    reg_check(32, 1, "R13 control");

    // R5 supervisor write without permission
    access(32'h800, 1, 0, 1, 1, "R5 sup write");
    reg_check(33, 32'h800, "R10 fault addr");
    reg_check(34, 32'h0005_0001, "R10 syndrome");
    // R11 clear
    reg_write(33, 0);
    reg_write(34, 0);
    reg_check(33, 0, "R11 fault addr cleared");
    reg_check(34, 0, "R11 syndrome cleared");
    access(32'h800, 0, 0, 0, 0, "R5 sup read");
    reg_check(33, 0, "R10 pass leaves addr");

    // R6 user permissions
    access(32'h1004, 1, 1, 0, 1, "R6 user write");
    reg_check(33, 32'h1004, "R10 fault addr user");
    reg_check(34, 32'h0003_0002, "R10 syndrome user write");
    access(32'h2000, 0, 1, 0, 1, "R6 user read");
    reg_check(34, 32'h0002_0004, "R10 syndrome user read");
    reg_write(18, 32'h13);
    access(32'h2000, 0, 1, 0, 0, "R6 user read-only read");
    access(32'h2000, 1, 1, 0, 1, "R6 user read-only write");

    // R7 clean page and R4 priority
    access(32'h3000, 1, 1, 0, 1, "R7 user write clean");
    reg_check(34, 32'h0003_0008, "R4 lowest descriptor named");
    access(32'h3010, 1, 0, 0, 1, "R7 sup write clean");
    access(32'h3000, 0, 1, 0, 0, "R7 read of clean page");

    // R8 generator restriction
    access(32'h4010, 1, 1, 1, 1, "R8 gen1 write");
    reg_check(34, 32'h0007_0010, "R8 syndrome gen1");
    access(32'h4010, 1, 1, 0, 0, "R8 gen0 write");

    // R3 page sizes and validity
    access(32'h00FF_FFFC, 0, 1, 0, 1, "R3 4M page top");
    reg_check(34, 32'h0002_0020, "R3 syndrome 4M");
    access(32'h0100_0000, 0, 1, 0, 0, "R3 past 4M page");
    access(32'h00C0_0000, 1, 0, 0, 0, "R3 4M sup write");
    access(32'h0001_0FFC, 0, 1, 0, 1, "R3 4K page top");
    reg_check(34, 32'h0002_0080, "R3 syndrome 4K");
    access(32'h0001_1000, 0, 1, 0, 0, "R3 past 4K page");
    access(32'h8000, 1, 1, 0, 0, "R3 invalid descriptor");

    // R12 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    acc_addr = 32'h1004; acc_write = 1; acc_user = 1; acc_gen1 = 0; acc_valid = 1;
    @(negedge clk);
    acc_addr = 32'h800; acc_write = 0; acc_user = 0;
    @(negedge clk);
    check("R12 stalled ready", {31'd0, acc_ready}, 0);
    check("R12 held verdict", {31'd0, rsp_fault}, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    check("R12 second verdict", {31'd0, rsp_fault}, 0);
    check("R12 second valid", {31'd0, rsp_valid}, 1);

    // R2 disabled again
    reg_write(32, 0);
    access(32'h1004, 1, 1, 0, 0, "R2 disabled user write");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule